// File: doc/BRIEF.md
# Dual-Channel Edge Input Capture

This block times events on a group of sixteen digital inputs with two independent capture channels. Each channel owns a 16-bit counter. The counter advances by one on each cycle in which the external prescaler enable (`tick_i`) is high, so the count rate can be anywhere from the full clock down to a fraction of it. Every input is brought into the clock domain through a two-flop synchroniser, and the edges are then found by comparing the synchronised value with its delayed copy.

Each channel has two event sources, called start and stop. Each source picks one input pin and reacts to a rising edge, a falling edge or either edge. Start and stop may use the same pin. An event always copies the current count into that source's capture register and sets a sticky flag, which raises the channel interrupt.

The channel mode decides what the events do to the counter:
- Free mode: the counter runs all the time, and the events only latch the count. The channel then acts as two independent edge timestamps.
- Gated mode: a start event zeroes the counter and starts it, and a stop event halts it. The stop capture then holds the pulse width.
- Run-to-stop mode: the counter runs after a software start and halts on a stop event.

Software can also clear the counter and start it directly. The counter wraps from 0xFFFF to 0 and sets a rollover flag when it does.

Each channel has a small state machine with two states:
- HALT: the counter is held.
- RUN: the counter advances on ticks.

Its transitions are:
- HALT→RUN on a software start.
- HALT→RUN when the mode is free.
- HALT→RUN on a start event in gated mode.
- RUN→HALT on a stop event in gated or run-to-stop mode.
- Every other case stays in the current state.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset, every count, capture register and flag is 0, and `irq_o` is 0.
- R2: An edge-select code of 2'b01 reacts to rising edges, 2'b10 to falling edges and 2'b11 to both. With 2'b00 the source makes no event, so no capture is taken and no flag is set.
- R3: Each start and stop source reads the input pin whose index is given by its 4-bit field. Channel c uses bits [4c+3:4c] of `start_sel_i` and `stop_sel_i`, and bits [2c+1:2c] of `start_edge_i`, `stop_edge_i` and `mode_i`. Start and stop may name the same pin.
- R4: While a channel is in RUN, its count rises by exactly 1 on each clock edge with `tick_i` high. Without a tick, a software clear or a gated start event, the count does not change.
- R5: With mode 2'b00 (2'b11 behaves the same), the channel enters RUN and stays there. Events latch the count without changing it.
- R6: With mode 2'b01 (gated), a start event zeroes the counter and puts the channel in RUN. A stop event while in RUN halts it with the count held.
- R7: With mode 2'b10 (run-to-stop), a pulse on `sw_start_i` puts the channel in RUN and a stop event halts it. Start events only latch the count.
- R8: Each event copies the count it sees, before that cycle's increment, into its capture register and sets its sticky flag. `irq_o[c]` is high while any flag of channel c is set.
- R9: A one-cycle pulse on `rd_start_i`, `rd_stop_i` or `rd_roll_i` clears the matching flag. A new event in that same cycle keeps the flag set.
- R10: A pulse on `sw_clear_i[c]` makes count c read 0 on the next cycle, whatever the tick.
- R11: When a tick in RUN takes the count from 0xFFFF, it becomes 0 and the rollover flag is set.
- R12: In gated mode, when start and stop events arrive in the same cycle, the stop acts if the channel is in RUN and the start acts if it is in HALT. Both captures are still taken.
- R13: The two channels are independent: a control, tick-free action or event on one leaves the other's count and flags alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler count enable |
| pins_i | input | 16 | Asynchronous event inputs |
| start_sel_i | input | 8 | Start pin index, 4 bits per channel |
| stop_sel_i | input | 8 | Stop pin index, 4 bits per channel |
| start_edge_i | input | 4 | Start edge select, 2 bits per channel |
| stop_edge_i | input | 4 | Stop edge select, 2 bits per channel |
| mode_i | input | 4 | Counting mode, 2 bits per channel |
| sw_clear_i | input | 2 | Software counter clear, per channel |
| sw_start_i | input | 2 | Software counter start, per channel |
| rd_start_i | input | 2 | Start-flag read acknowledge |
| rd_stop_i | input | 2 | Stop-flag read acknowledge |
| rd_roll_i | input | 2 | Rollover-flag read acknowledge |
| count_o | output | 32 | Live counts, 16 bits per channel |
| cap_start_o | output | 32 | Start capture registers |
| cap_stop_o | output | 32 | Stop capture registers |
| flag_start_o | output | 2 | Start capture flags |
| flag_stop_o | output | 2 | Stop capture flags |
| flag_roll_o | output | 2 | Rollover flags |
| irq_o | output | 2 | Per-channel interrupt |

## Verification
The case that matters most is a start event and a stop event landing in the same cycle. This happens when both sources watch the same pin on both edges in gated mode. The bench provokes it with single toggles of one pin:
- A rising toggle while the channel is in HALT must take both captures and restart the count from 0. The bench judges this by the count after a known number of ticks.
- The falling toggle that follows, while the channel is in RUN, must take both captures and freeze the count. The bench judges this by giving more ticks and finding the count unchanged.

A scoreboard queue holds the capture value expected for each flag rise and checks them in the order they occur.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_GATED    = 2'b01,
        MODE_TO_STOP  = 2'b10,
        MODE_FREE_ALT = 2'b11
    } mode_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise_o = sync_q & ~prev_q;
        fall_o = ~sync_q & prev_q;
    end
endmodule

// File: rtl/cap_event_sel.sv
module cap_event_sel
    import cap_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int SEL_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [1:0]          edge_sel_i,
    output logic                ev_o
);
    edge_e kind;

    always_comb begin
        kind = edge_e'(edge_sel_i);
        unique case (kind)
            EDGE_OFF:  ev_o = 1'b0;
            EDGE_RISE: ev_o = rise_i[sel_i];
            EDGE_FALL: ev_o = fall_i[sel_i];
            EDGE_ANY:  ev_o = rise_i[sel_i] | fall_i[sel_i];
        endcase
    end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ev_start_i,
    input  logic             ev_stop_i,
    input  logic [1:0]       mode_i,
    input  logic             sw_clear_i,
    input  logic             sw_start_i,
    input  logic             rd_start_i,
    input  logic             rd_stop_i,
    input  logic             rd_roll_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cap_start_o,
    output logic [CNT_W-1:0] cap_stop_o,
    output logic             flag_start_o,
    output logic             flag_stop_o,
    output logic             flag_roll_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e state_q, state_d;
    mode_e      mode;
    logic       free_run, gated, halts_on_stop;
    logic       running, clr, advance, wrap;

    always_comb begin
        mode          = mode_e'(mode_i);
        free_run      = (mode == MODE_FREE) || (mode == MODE_FREE_ALT);
        gated         = (mode == MODE_GATED);
        halts_on_stop = (mode == MODE_GATED) || (mode == MODE_TO_STOP);
        running       = (state_q == ST_RUN);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (sw_start_i || free_run || (gated && ev_start_i))
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (halts_on_stop && ev_stop_i)
                    state_d = ST_HALT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HALT;
        else         state_q <= state_d;
    end

    // a gated start restarts the count unless a coincident stop wins in RUN (R12)
    always_comb begin
        clr     = sw_clear_i || (gated && ev_start_i && !(running && ev_stop_i));
        advance = tick_i && running && !clr;
        wrap    = advance && (count_o == CNT_MAX);
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_o      <= '0;
            cap_start_o  <= '0;
            cap_stop_o   <= '0;
            flag_start_o <= 1'b0;
            flag_stop_o  <= 1'b0;
            flag_roll_o  <= 1'b0;
        end else begin
            if (clr)          count_o <= '0;
            else if (advance) count_o <= count_o + 1'b1;

            if (ev_start_i) cap_start_o <= count_o;
            if (ev_stop_i)  cap_stop_o  <= count_o;

            if (ev_start_i)      flag_start_o <= 1'b1;
            else if (rd_start_i) flag_start_o <= 1'b0;

            if (ev_stop_i)      flag_stop_o <= 1'b1;
            else if (rd_stop_i) flag_stop_o <= 1'b0;

            if (wrap)           flag_roll_o <= 1'b1;
            else if (rd_roll_i) flag_roll_o <= 1'b0;
        end
    end

    assign irq_o = flag_start_o | flag_stop_o | flag_roll_o;
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import cap_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int CNT_W    = 16,
    parameter int NUM_PINS = 16,
    localparam int SEL_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      tick_i,
    input  logic [NUM_PINS-1:0]       pins_i,
    input  logic [NUM_CH*SEL_W-1:0]   start_sel_i,
    input  logic [NUM_CH*SEL_W-1:0]   stop_sel_i,
    input  logic [NUM_CH*2-1:0]       start_edge_i,
    input  logic [NUM_CH*2-1:0]       stop_edge_i,
    input  logic [NUM_CH*2-1:0]       mode_i,
    input  logic [NUM_CH-1:0]         sw_clear_i,
    input  logic [NUM_CH-1:0]         sw_start_i,
    input  logic [NUM_CH-1:0]         rd_start_i,
    input  logic [NUM_CH-1:0]         rd_stop_i,
    input  logic [NUM_CH-1:0]         rd_roll_i,
    output logic [NUM_CH*CNT_W-1:0]   count_o,
    output logic [NUM_CH*CNT_W-1:0]   cap_start_o,
    output logic [NUM_CH*CNT_W-1:0]   cap_stop_o,
    output logic [NUM_CH-1:0]         flag_start_o,
    output logic [NUM_CH-1:0]         flag_stop_o,
    output logic [NUM_CH-1:0]         flag_roll_o,
    output logic [NUM_CH-1:0]         irq_o
);
    logic [NUM_PINS-1:0] rise, fall;
    logic [NUM_CH-1:0]   ev_start, ev_stop;

    cap_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cap_event_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_start_sel (
            .rise_i     (rise),
            .fall_i     (fall),
            .sel_i      (start_sel_i[c*SEL_W +: SEL_W]),
            .edge_sel_i (start_edge_i[2*c +: 2]),
            .ev_o       (ev_start[c])
        );

        cap_event_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_stop_sel (
            .rise_i     (rise),
            .fall_i     (fall),
            .sel_i      (stop_sel_i[c*SEL_W +: SEL_W]),
            .edge_sel_i (stop_edge_i[2*c +: 2]),
            .ev_o       (ev_stop[c])
        );

        cap_channel #(.CNT_W(CNT_W)) u_chan (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .tick_i       (tick_i),
            .ev_start_i   (ev_start[c]),
            .ev_stop_i    (ev_stop[c]),
            .mode_i       (mode_i[2*c +: 2]),
            .sw_clear_i   (sw_clear_i[c]),
            .sw_start_i   (sw_start_i[c]),
            .rd_start_i   (rd_start_i[c]),
            .rd_stop_i    (rd_stop_i[c]),
            .rd_roll_i    (rd_roll_i[c]),
            .count_o      (count_o[c*CNT_W +: CNT_W]),
            .cap_start_o  (cap_start_o[c*CNT_W +: CNT_W]),
            .cap_stop_o   (cap_stop_o[c*CNT_W +: CNT_W]),
            .flag_start_o (flag_start_o[c]),
            .flag_stop_o  (flag_stop_o[c]),
            .flag_roll_o  (flag_roll_o[c]),
            .irq_o        (irq_o[c])
        );
    end
endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    tick_i,
    input logic [NUM_CH*2-1:0]     mode_i,
    input logic [NUM_CH-1:0]       sw_clear_i,
    input logic [NUM_CH-1:0]       rd_start_i,
    input logic [NUM_CH-1:0]       rd_stop_i,
    input logic [NUM_CH-1:0]       rd_roll_i,
    input logic [NUM_CH*CNT_W-1:0] count_o,
    input logic [NUM_CH-1:0]       flag_start_o,
    input logic [NUM_CH-1:0]       flag_stop_o,
    input logic [NUM_CH-1:0]       flag_roll_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!$past(tick_i) && !$past(sw_clear_i[c]) && ($past(mode_i[2*c +: 2]) != 2'b01))
            |-> $stable(count_o[c*CNT_W +: CNT_W]));

        p_sw_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(sw_clear_i[c]) |-> (count_o[c*CNT_W +: CNT_W] == '0));

        p_wrap_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flag_roll_o[c]) |-> (count_o[c*CNT_W +: CNT_W] == '0));

        p_sticky_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_start_o[c] && !rd_start_i[c]) |=> flag_start_o[c]);

        p_sticky_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_stop_o[c] && !rd_stop_i[c]) |=> flag_stop_o[c]);

        p_sticky_roll_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_roll_o[c] && !rd_roll_i[c]) |=> flag_roll_o[c]);
    end
endmodule

bind dual_edge_capture dual_edge_capture_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .mode_i       (mode_i),
    .sw_clear_i   (sw_clear_i),
    .rd_start_i   (rd_start_i),
    .rd_stop_i    (rd_stop_i),
    .rd_roll_i    (rd_roll_i),
    .count_o      (count_o),
    .flag_start_o (flag_start_o),
    .flag_stop_o  (flag_stop_o),
    .flag_roll_o  (flag_roll_o)
);

// File: tb/sim_dual_edge_capture.sv
`timescale 1ns/1ps
module sim_dual_edge_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] pins = '0;
    logic [7:0]  start_sel = '0, stop_sel = '0;
    logic [3:0]  start_edge = '0, stop_edge = '0, mode = '0;
    logic [1:0]  sw_clear = '0, sw_start = '0, rd_start = '0, rd_stop = '0, rd_roll = '0;
    logic [31:0] count, cap_start, cap_stop;
    logic [1:0]  flag_start, flag_stop, flag_roll, irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int          ch;
        int          kind;
        logic [15:0] val;
        string       req;
    } item_t;
    item_t exp_q[$];
    logic [1:0][1:0] prev = '0;

    always #2 clk = ~clk;

    dual_edge_capture u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pins_i(pins),
        .start_sel_i(start_sel), .stop_sel_i(stop_sel),
        .start_edge_i(start_edge), .stop_edge_i(stop_edge), .mode_i(mode),
        .sw_clear_i(sw_clear), .sw_start_i(sw_start),
        .rd_start_i(rd_start), .rd_stop_i(rd_stop), .rd_roll_i(rd_roll),
        .count_o(count), .cap_start_o(cap_start), .cap_stop_o(cap_stop),
        .flag_start_o(flag_start), .flag_stop_o(flag_stop),
        .flag_roll_o(flag_roll), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_cap(input int ch, input int kind, input int val, input string req);
        item_t it;
        it.ch = ch; it.kind = kind; it.val = val[15:0]; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: each rising capture flag consumes one expected item
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 2; k++) begin
                    logic        f;
                    logic [15:0] v;
                    item_t       it;
                    f = (k == 0) ? flag_start[c] : flag_stop[c];
                    v = (k == 0) ? cap_start[c*16 +: 16] : cap_stop[c*16 +: 16];
                    if (f && !prev[c][k]) begin
                        tests++;
                        if (exp_q.size() == 0) begin
                            fails++;
                            $display("FAIL R8 unexpected capture ch%0d kind%0d actual=%0h expected=none", c, k, v);
                        end else begin
                            it = exp_q.pop_front();
                            if (it.ch != c || it.kind != k || it.val !== v) begin
                                fails++;
                                $display("FAIL %s ch%0d kind%0d actual=%0h expected ch%0d kind%0d %0h",
                                         it.req, c, k, v, it.ch, it.kind, it.val);
                            end
                        end
                    end
                    prev[c][k] = f;
                end
            end
        end
    end

    task automatic ticks(input int n);
        @(negedge clk) tick = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk) pins[i] = v;
        idle(5);
    endtask

    task automatic pulse_clear(input int ch);
        @(negedge clk) sw_clear[ch] = 1'b1;
        @(negedge clk) sw_clear[ch] = 1'b0;
    endtask

    task automatic pulse_start(input int ch);
        @(negedge clk) sw_start[ch] = 1'b1;
        @(negedge clk) sw_start[ch] = 1'b0;
    endtask

    task automatic read_flags(input logic [1:0] s, input logic [1:0] p, input logic [1:0] r);
        @(negedge clk) begin rd_start = s; rd_stop = p; rd_roll = r; end
        @(negedge clk) begin rd_start = '0; rd_stop = '0; rd_roll = '0; end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        check("R1 count", count, 32'h0);
        check("R1 caps", {cap_start, cap_stop}, 32'h0);
        check("R1 flags", {24'h0, flag_start, flag_stop, flag_roll}, 32'h0);
        check("R1 irq", {30'h0, irq}, 32'h0);

        // R4 counting on ticks, free mode on both channels
        ticks(5);
        check("R4 ch0 after 5 ticks", count[15:0], 5);
        idle(3);
        check("R4 no tick no change", count[15:0], 5);

        // R10 / R13 software clear on ch0 only
        pulse_clear(0);
        check("R10 ch0 cleared", count[15:0], 0);
        check("R13 ch1 untouched", count[31:16], 5);

        // R3 / R5 free mode: pin 3 rising starts, falling stops
        start_sel[3:0] = 4'd3; stop_sel[3:0] = 4'd3;
        start_edge[1:0] = 2'b01; stop_edge[1:0] = 2'b10;
        ticks(7);
        expect_cap(0, 0, 7, "R3 start pin3 rise");
        set_pin(3, 1'b1);
        check("R8 irq ch0 raised", {31'h0, irq[0]}, 1);
        check("R13 ch1 flags quiet", {30'h0, flag_start[1], flag_stop[1]}, 0);
        ticks(2);
        expect_cap(0, 1, 9, "R5 stop pin3 fall");
        set_pin(3, 1'b0);
        check("R5 count unaffected by events", count[15:0], 9);
        read_flags(2'b01, 2'b01, 2'b00);
        check("R9 ch0 flags cleared", {30'h0, flag_start[0], flag_stop[0]}, 0);
        check("R9 irq ch0 low", {31'h0, irq[0]}, 0);

        // R2 both-edge start on pin 5, stop disabled on ch1
        start_sel[7:4] = 4'd5; stop_sel[7:4] = 4'd5;
        start_edge[3:2] = 2'b11; stop_edge[3:2] = 2'b00;
        pulse_clear(1);
        ticks(4);
        expect_cap(1, 0, 4, "R2 any-edge rise");
        set_pin(5, 1'b1);
        check("R8 ch1 flag sticky", {31'h0, flag_start[1]}, 1);
        read_flags(2'b10, 2'b00, 2'b00);
        expect_cap(1, 0, 4, "R2 any-edge fall");
        set_pin(5, 1'b0);
        check("R2 disabled stop no flag", {31'h0, flag_stop[1]}, 0);
        check("R2 disabled stop no capture", cap_stop[31:16], 0);
        read_flags(2'b10, 2'b00, 2'b00);

        // R6 gated mode on ch0, pin 1
        mode[1:0] = 2'b01;
        start_sel[3:0] = 4'd1; stop_sel[3:0] = 4'd1;
        start_edge[1:0] = 2'b01; stop_edge[1:0] = 2'b10;
        pulse_clear(0);
        expect_cap(0, 0, 0, "R6 gated start");
        set_pin(1, 1'b1);
        ticks(10);
        check("R6 gated count", count[15:0], 10);
        expect_cap(0, 1, 10, "R6 gated width");
        set_pin(1, 1'b0);
        read_flags(2'b01, 2'b01, 2'b00);
        ticks(4);
        check("R6 halted after stop", count[15:0], 10);
        expect_cap(0, 0, 10, "R6 restart capture");
        set_pin(1, 1'b1);
        ticks(3);
        check("R6 restart from zero", count[15:0], 3);
        expect_cap(0, 1, 3, "R6 second width");
        set_pin(1, 1'b0);
        read_flags(2'b01, 2'b01, 2'b00);

        // R7 run-to-stop on ch1: stop on pin 2 rise, start on pin 4 rise
        mode[3:2] = 2'b10;
        start_sel[7:4] = 4'd4; stop_sel[7:4] = 4'd2;
        start_edge[3:2] = 2'b01; stop_edge[3:2] = 2'b01;
        pulse_clear(1);
        expect_cap(1, 1, 0, "R7 stop halts");
        set_pin(2, 1'b1);
        read_flags(2'b00, 2'b10, 2'b00);
        ticks(3);
        check("R7 held while halted", count[31:16], 0);
        set_pin(2, 1'b0);
        pulse_start(1);
        ticks(6);
        check("R7 runs after sw start", count[31:16], 6);
        expect_cap(1, 0, 6, "R7 start only latches");
        set_pin(4, 1'b1);
        ticks(2);
        check("R7 start did not clear", count[31:16], 8);
        expect_cap(1, 1, 8, "R7 stop capture");
        set_pin(2, 1'b1);
        ticks(3);
        check("R7 halted on stop", count[31:16], 8);
        read_flags(2'b10, 2'b10, 2'b00);

        // R12 coincident start and stop on pin 6, both edges, ch0 gated (halted at 3)
        start_sel[3:0] = 4'd6; stop_sel[3:0] = 4'd6;
        start_edge[1:0] = 2'b11; stop_edge[1:0] = 2'b11;
        expect_cap(0, 0, 3, "R12 coincident start");
        expect_cap(0, 1, 3, "R12 coincident stop");
        set_pin(6, 1'b1);
        read_flags(2'b01, 2'b01, 2'b00);
        ticks(4);
        check("R12 halted: start wins", count[15:0], 4);
        expect_cap(0, 0, 4, "R12 coincident start 2");
        expect_cap(0, 1, 4, "R12 coincident stop 2");
        set_pin(6, 1'b0);
        ticks(2);
        check("R12 running: stop wins", count[15:0], 4);
        read_flags(2'b01, 2'b01, 2'b00);

        // R11 rollover on ch1 in free mode
        mode[3:2] = 2'b00;
        idle(2);
        pulse_clear(1);
        ticks(65535);
        check("R11 at max", count[31:16], 16'hFFFF);
        check("R11 no early roll", {31'h0, flag_roll[1]}, 0);
        ticks(1);
        check("R11 wrapped", count[31:16], 0);
        check("R11 roll flag", {31'h0, flag_roll[1]}, 1);
        check("R8 irq on roll", {31'h0, irq[1]}, 1);
        read_flags(2'b00, 2'b00, 2'b10);
        check("R9 roll cleared", {30'h0, flag_roll}, 0);
        check("R9 irq cleared", {30'h0, irq}, 0);

        idle(4);
        check("R8 all expected captures seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule